// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block is a single-channel I2C bus master. Software drives it through four byte-wide registers: control, status, interrupt enable and data. Software writes a command value to the control register to start the bus, to turn it around for reading, or to end a transfer with a STOP. The block then moves one byte at a time and reports each byte boundary through status flags. Each flag has its own enable bit, and all enabled flags feed one interrupt line.

Each byte follows a fixed sequence. The block first shifts eight bits, MSB first. It then raises the wait flag and holds SCL low until software clears that flag. Next comes the acknowledge clock, with the missing-acknowledge flag raised if the target did not acknowledge. Last, the data-empty flag rises. SCL and SDA are open-drain outputs, and their levels are read back through a synchronizer. Bit timing comes from an external strobe: each strobe pulse moves the bus one half-bit phase forward.

Top module: `i2cseq_master`

## Requirements
- R1: After reset, status (address 1) reads 0xC0 with an idle bus: bit 7 is the sampled SCL level and bit 6 the sampled SDA level, and all flags and BUSY (bit 4) read 0. The interrupt output is low and neither open-drain output pulls low.
- R2: Writing 0x94 to control (address 0) on an idle enabled bus produces a START: SDA falls while SCL is high, then SCL goes low. After that, data-empty (status bit 0) and BUSY are set.
- R3: A byte written to data (address 3) is shifted out MSB first. SDA changes only while SCL is low, so the target receives exactly that byte.
- R4: After the eighth bit the wait flag (status bit 1) is set and SCL stays low for as long as it remains set. Writing 0 to that bit releases the acknowledge clock.
- R5: Data-empty is set only after the acknowledge clock and never while the wait flag is pending. The missing-acknowledge flag (status bit 2) is set when SDA is high at the acknowledge sample of a transmitted byte.
- R6: Writing 0x90 to control makes a STOP follow the current byte. BUSY clears only when that STOP has completed on the bus.
- R7: After a read address byte, writing 0x81 starts reception, and each received byte is acknowledged. Data reads back the last shifted byte. Writing 0xC0 before the wait flag is cleared makes the block not-acknowledge that byte and then send a STOP.
- R8: Entering receive mode always receives at least one byte. Writing 0xC1 directly yields exactly one byte, not acknowledged, followed by a STOP.
- R9: Arbitration-lost (status bit 3) is set when the block releases SDA for a 1 bit of a transmitted byte but samples SDA low.
- R10: In a status write, a 0 in a flag bit clears that flag and a 1 leaves it unchanged.
- R11: The interrupt output is the OR of each flag ANDed with the interrupt-enable bit at the same position (address 2, bits 3..0).
- R12: Writing 0x94 while a transfer is held between bytes issues a repeated START without a STOP. BUSY stays 1 throughout, and data-empty marks the end of the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_tick | input | 1 | Half-bit phase strobe from the external SCL timing generator |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 interrupt enable, 3 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Combined interrupt |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest case to reach from the ports is arbitration loss. It needs a second driver to pull SDA low during the exact bit phases where the block has released the line. The bench's target model has a jam control for this. The bench raises it just after loading a byte whose MSB is 1, while SCL is still held low, and drops it once the wait flag holds the bus. This makes the lost bit fall inside a transmitted byte and never creates a false START or STOP.

// File: rtl/i2cseq_pkg.sv
`timescale 1ns/1ps
package i2cseq_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int FLAG_N    = 4;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_IEN  = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    // bus phases; each advances on one timing strobe
    typedef enum logic [3:0] {
        ST_IDLE, ST_RS_LO, ST_RS_HI, ST_SDA_DN, ST_SCL_DN, ST_HOLD,
        ST_BIT_LO, ST_BIT_HI, ST_WAIT_LO, ST_ACK_LO, ST_ACK_HI,
        ST_STP_LO, ST_STP_HI, ST_STP_REL
    } seq_state_e;

    // bit order matches status bits 3..0
    typedef struct packed {
        logic al;
        logic tack;
        logic hold;
        logic dte;
    } flags_t;
endpackage

// File: rtl/i2cseq_sync.sv
`timescale 1ns/1ps
module i2cseq_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb pipe_d = {pipe_q[STAGES-2:0], din};
        end else begin : g_single
            always_comb pipe_d = din;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;   // idle bus reads high
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/i2cseq_engine.sv
`timescale 1ns/1ps
module i2cseq_engine
    import i2cseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              tx_dir,
    input  logic              nack_ctl,
    input  logic              hold_bus,
    input  logic              start_pulse,
    input  logic              rx_restart,
    input  logic              load_pulse,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              wait_flag,
    input  logic              sda_s,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic [BYTE_W-1:0] shift_out,
    output logic              set_dte,
    output logic              set_wait,
    output logic              set_tack,
    output logic              set_al
);
    typedef struct packed {
        seq_state_e           st;
        logic [BIT_CNT_W-1:0] cnt;
        logic [BYTE_W-1:0]    sh;
        logic [BYTE_W-1:0]    txd;
        logic                 load;
        logic                 start;
        logic                 rxb;
        logic                 rxgot;
        logic                 nackb;
    } eng_t;

    localparam eng_t ENG_RST = '{st: ST_IDLE, default: '0};
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    eng_t q, d;

    always_comb begin
        d        = q;
        set_dte  = 1'b0;
        set_wait = 1'b0;
        set_tack = 1'b0;
        set_al   = 1'b0;
        if (load_pulse) begin
            d.txd  = load_data;
            d.load = 1'b1;
        end
        if (start_pulse) d.start = 1'b1;
        if (rx_restart)  d.rxgot = 1'b0;
        if (!enable) begin
            d.st    = ST_IDLE;
            d.start = 1'b0;
            d.load  = 1'b0;
        end else if (tick) begin
            unique case (q.st)
                ST_IDLE: if (q.start) begin
                    d.st    = ST_RS_HI;
                    d.start = 1'b0;
                end
                ST_RS_LO:  d.st = ST_RS_HI;
                ST_RS_HI:  d.st = ST_SDA_DN;
                ST_SDA_DN: d.st = ST_SCL_DN;
                ST_SCL_DN: begin
                    d.st    = ST_HOLD;
                    set_dte = 1'b1;
                end
                ST_HOLD: begin
                    if (q.start) begin
                        d.st    = ST_RS_LO;
                        d.start = 1'b0;
                    end else if (!tx_dir) begin
                        if (!q.rxgot || !nack_ctl) begin
                            d.st    = ST_BIT_LO;
                            d.cnt   = '0;
                            d.rxb   = 1'b1;
                            d.rxgot = 1'b1;
                        end else begin
                            d.st = ST_STP_LO;
                        end
                    end else if (q.load) begin
                        d.st   = ST_BIT_LO;
                        d.cnt  = '0;
                        d.sh   = q.txd;
                        d.load = 1'b0;
                        d.rxb  = 1'b0;
                    end else if (!hold_bus) begin
                        d.st = ST_STP_LO;
                    end
                end
                ST_BIT_LO: d.st = ST_BIT_HI;
                ST_BIT_HI: begin
                    if (!q.rxb && q.sh[BYTE_W-1] && !sda_s) set_al = 1'b1;
                    d.sh = {q.sh[BYTE_W-2:0], sda_s};
                    if (q.cnt == LAST_BIT) begin
                        d.st     = ST_WAIT_LO;
                        set_wait = 1'b1;
                    end else begin
                        d.cnt = q.cnt + BIT_CNT_W'(1);
                        d.st  = ST_BIT_LO;
                    end
                end
                ST_WAIT_LO: if (!wait_flag) begin
                    d.nackb = nack_ctl;
                    d.st    = ST_ACK_LO;
                end
                ST_ACK_LO: d.st = ST_ACK_HI;
                ST_ACK_HI: begin
                    if (!q.rxb && sda_s) set_tack = 1'b1;
                    set_dte = 1'b1;
                    d.st    = ST_HOLD;
                end
                ST_STP_LO:  d.st = ST_STP_HI;
                ST_STP_HI:  d.st = ST_STP_REL;
                ST_STP_REL: d.st = ST_IDLE;
                default:    d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= d;
    end

    always_comb begin
        unique case (q.st)
            ST_SDA_DN, ST_SCL_DN, ST_STP_LO, ST_STP_HI: sda_oe = 1'b1;
            ST_BIT_LO, ST_BIT_HI: sda_oe = !q.rxb && !q.sh[BYTE_W-1];
            ST_ACK_LO, ST_ACK_HI: sda_oe = q.rxb && !q.nackb;
            default:              sda_oe = 1'b0;
        endcase
        scl_oe = q.st inside {ST_RS_LO, ST_SCL_DN, ST_HOLD, ST_BIT_LO,
                              ST_WAIT_LO, ST_ACK_LO, ST_STP_LO};
    end

    assign busy      = (q.st != ST_IDLE);
    assign shift_out = q.sh;

    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_BIT_HI || q.st == ST_ACK_HI) && $past(q.st) == q.st) |-> $stable(sda_oe))
        else $error("SDA moved while SCL high in a bit"); // R3

    AST_BUSY_ENDS_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && enable) |-> $past(q.st) == ST_STP_REL)
        else $error("BUSY cleared without a STOP"); // R6
endmodule

// File: rtl/i2cseq_master.sv
`timescale 1ns/1ps
module i2cseq_master
    import i2cseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tick,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe
);
    typedef struct packed {
        logic              en;
        logic              nack;
        logic              dir;
        logic              bbsy;
        logic [FLAG_N-1:0] ien;
        flags_t            fl;
    } regs_t;

    regs_t q, d;
    logic [1:0] bus_s;   // {scl, sda}
    logic busy, set_dte, set_wait, set_tack, set_al;
    logic start_p, rxr_p, load_p, ctrl_wr;
    logic [BYTE_W-1:0] shift_byte;

    i2cseq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(bus_s));

    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign start_p = ctrl_wr && reg_wdata[7] && reg_wdata[4] && reg_wdata[2];
    assign rxr_p   = ctrl_wr && reg_wdata[0];
    assign load_p  = reg_wr && (reg_addr == A_DATA);

    i2cseq_engine u_eng (
        .clk(clk), .rst_n(rst_n), .tick(bus_tick),
        .enable(q.en), .tx_dir(q.dir), .nack_ctl(q.nack), .hold_bus(q.bbsy),
        .start_pulse(start_p), .rx_restart(rxr_p),
        .load_pulse(load_p), .load_data(reg_wdata),
        .wait_flag(q.fl.hold), .sda_s(bus_s[0]),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .shift_out(shift_byte),
        .set_dte(set_dte), .set_wait(set_wait), .set_tack(set_tack), .set_al(set_al));

    always_comb begin
        d = q;
        if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL: begin
                    d.en   = reg_wdata[7];
                    d.nack = reg_wdata[6];
                    d.dir  = reg_wdata[4];
                    d.bbsy = reg_wdata[2];
                end
                A_STAT: d.fl  = flags_t'(q.fl & reg_wdata[FLAG_N-1:0]);
                A_IEN:  d.ien = reg_wdata[FLAG_N-1:0];
                default: ;
            endcase
        end
        if (set_dte)  d.fl.dte  = 1'b1;
        if (set_wait) d.fl.hold = 1'b1;
        if (set_tack) d.fl.tack = 1'b1;
        if (set_al)   d.fl.al   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {q.en, q.nack, 1'b0, q.dir, 1'b0, q.bbsy, 2'b00};
            A_STAT:  reg_rdata = {bus_s[1], bus_s[0], 1'b0, busy, q.fl};
            A_IEN:   reg_rdata = {{(BYTE_W-FLAG_N){1'b0}}, q.ien};
            default: reg_rdata = shift_byte;
        endcase
    end

    assign irq = |(q.fl & q.ien);

    AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fl.hold && q.en && busy) |-> scl_oe)
        else $error("SCL released while WAIT pending"); // R4

    AST_DTE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.fl.dte) |-> !q.fl.hold)
        else $error("DTE rose ahead of WAIT release"); // R5

    AST_AL_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.fl.al) |-> !$past(sda_oe))
        else $error("AL raised while SDA was driven"); // R9
endmodule

// File: tb/i2cseq_master_test.sv
`timescale 1ns/1ps
module i2cseq_master_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_tick = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic irq, scl_oe, sda_oe, scl_i, sda_i;

    int nchk = 0, nfail = 0;

    // target model state
    logic pull = 1'b0, jam = 1'b0, slv_ack = 1'b1;
    logic ps_scl = 1'b1, ps_sda = 1'b1, rd = 1'b0, mnack = 1'b0;
    logic [7:0] sin = 8'h00, slv_last = 8'h00, rbase = 8'h00, cur;
    int bitn = -1, byten = 0, starts = 0, stops = 0, wbytes = 0;

    assign scl_i = ~scl_oe;
    assign sda_i = ~(sda_oe | pull | jam);

    i2cseq_master uut (
        .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe));

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            repeat (7) @(negedge clk);
            bus_tick = 1'b1;
            @(negedge clk);
            bus_tick = 1'b0;
        end
    end

    // simple target: acks writes, returns rbase+n on reads
    always @(negedge clk) begin
        if (scl_i && ps_scl && ps_sda && !sda_i) begin
            bitn = -1; byten = 0; pull = 1'b0; mnack = 1'b0; starts++;
        end else if (scl_i && ps_scl && !ps_sda && sda_i) begin
            bitn = -1; pull = 1'b0; stops++;
        end else if (scl_i && !ps_scl) begin
            if (bitn >= 0 && bitn < 8) sin = {sin[6:0], sda_i};
            else if (bitn == 8 && rd && byten > 0) mnack = sda_i;
        end else if (!scl_i && ps_scl) begin
            bitn++;
            cur = rbase + 8'(byten - 1);
            if (bitn == 8) begin
                if (byten == 0) rd = sin[0];
                if (byten == 0 || !rd) begin
                    pull = slv_ack;
                    if (byten > 0) begin slv_last = sin; wbytes++; end
                end else pull = 1'b0;
            end else if (bitn == 9) begin
                bitn = 0; byten++;
                cur = rbase + 8'(byten - 1);
                pull = (rd && !mnack) ? !cur[7] : 1'b0;
            end else if (bitn >= 1 && bitn <= 7) begin
                pull = (rd && byten > 0 && !mnack) ? !cur[7-bitn] : 1'b0;
            end
        end
        ps_scl = scl_i; ps_sda = sda_i;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdr(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic poll(input logic [7:0] mask, input logic [7:0] val, input string req);
        logic [7:0] s;
        int n;
        n = 0;
        rdr(2'd1, s);
        while ((s & mask) != val && n < 5000) begin
            rdr(2'd1, s);
            n++;
        end
        if (n >= 5000) chk(req, {24'd0, s & mask}, {24'd0, val});
    endtask

    task automatic start_addr(input logic [7:0] addr);
        int s0;
        logic [7:0] s;
        s0 = starts;
        wr(2'd0, 8'h94);
        poll(8'h01, 8'h01, "R2 dte after start");
        rdr(2'd1, s);
        chk("R2 busy after start", {31'd0, s[4]}, 32'd1);
        chk("R2 start seen", starts, s0 + 1);
        wr(2'd1, 8'hFE);
        wr(2'd3, addr);
    endtask

    task automatic finish_byte();
        poll(8'h02, 8'h02, "R4 wait");
        wr(2'd1, 8'hFD);
        poll(8'h01, 8'h01, "R5 dte");
    endtask

    task automatic stop_bus(input string req);
        int p0;
        p0 = stops;
        wr(2'd0, 8'h90);
        poll(8'h10, 8'h00, req);
        chk({req, " stop seen"}, stops, p0 + 1);
    endtask

    // {target ack, address byte (write), data byte}
    localparam logic [16:0] VECS [4] = '{17'h1A05A, 17'h13CFF, 17'h04200, 17'h1FE81};

    initial begin
        logic [7:0] s, v;
        int w0, busy_low;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rdr(2'd1, s);
        chk("R1 status reset", {24'd0, s}, 32'hC0);
        chk("R1 irq reset", {31'd0, irq}, 32'd0);
        chk("R1 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);

        wr(2'd0, 8'h80);
        wr(2'd2, 8'h00);

        for (int i = 0; i < 4; i++) begin
            slv_ack = VECS[i][16];
            start_addr(VECS[i][15:8]);
            finish_byte();
            rdr(2'd1, s);
            chk("R5 tack", {31'd0, s[2]}, {31'd0, !VECS[i][16]});
            wr(2'd1, 8'hFA);
            if (VECS[i][16]) begin
                w0 = wbytes;
                wr(2'd3, VECS[i][7:0]);
                finish_byte();
                wr(2'd1, 8'hFE);
                chk("R3 byte received", {24'd0, slv_last}, {24'd0, VECS[i][7:0]});
                chk("R3 byte count", wbytes, w0 + 1);
            end
            stop_bus("R6 busy clear");
        end
        slv_ack = 1'b1;

        // R4 hold, R10 write-one, R11 irq mask
        start_addr(8'hA0);
        poll(8'h02, 8'h02, "R4 wait");
        repeat (40) @(negedge clk);
        chk("R4 scl held", {31'd0, scl_oe}, 32'd1);
        rdr(2'd1, s);
        chk("R4 wait stays", {31'd0, s[1]}, 32'd1);
        chk("R5 no dte during wait", {31'd0, s[0]}, 32'd0);
        wr(2'd1, 8'hFD);
        poll(8'h01, 8'h01, "R5 dte");
        wr(2'd1, 8'hFF);
        rdr(2'd1, s);
        chk("R10 write one keeps", {31'd0, s[0]}, 32'd1);
        wr(2'd2, 8'h01);
        @(negedge clk);
        chk("R11 irq on", {31'd0, irq}, 32'd1);
        wr(2'd2, 8'h0E);
        @(negedge clk);
        chk("R11 irq masked", {31'd0, irq}, 32'd0);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'hFE);
        rdr(2'd1, s);
        chk("R10 write zero clears", {31'd0, s[0]}, 32'd0);
        stop_bus("R6 busy clear");

        // R7 two-byte read
        rbase = 8'hC5;
        start_addr(8'hA1);
        finish_byte();
        wr(2'd1, 8'hFA);
        wr(2'd0, 8'h81);
        poll(8'h02, 8'h02, "R7 wait b1");
        rdr(2'd3, v);
        chk("R7 first byte", {24'd0, v}, 32'hC5);
        wr(2'd1, 8'hFD);
        poll(8'h02, 8'h02, "R7 wait b2");
        rdr(2'd3, v);
        chk("R7 second byte", {24'd0, v}, 32'hC6);
        wr(2'd0, 8'hC0);
        wr(2'd1, 8'hFD);
        poll(8'h10, 8'h00, "R7 busy clear");
        chk("R7 nack last", {31'd0, mnack}, 32'd1);
        wr(2'd1, 8'hF0);

        // R8 receive with nack already set
        rbase = 8'h3B;
        start_addr(8'hA1);
        finish_byte();
        wr(2'd1, 8'hFA);
        wr(2'd0, 8'hC1);
        poll(8'h02, 8'h02, "R8 wait");
        rdr(2'd3, v);
        chk("R8 one byte", {24'd0, v}, 32'h3B);
        wr(2'd1, 8'hFD);
        poll(8'h10, 8'h00, "R8 busy clear");
        chk("R8 nack", {31'd0, mnack}, 32'd1);
        wr(2'd1, 8'hF0);

        // R12 repeated start
        start_addr(8'hA0);
        finish_byte();
        wr(2'd1, 8'hFE);
        w0 = starts;
        busy_low = 0;
        wr(2'd0, 8'h94);
        rdr(2'd1, s);
        while (!s[0]) begin
            if (!s[4]) busy_low++;
            rdr(2'd1, s);
        end
        chk("R12 busy kept", busy_low, 0);
        chk("R12 restart seen", starts, w0 + 1);
        wr(2'd1, 8'hFE);
        wr(2'd3, 8'hA0);
        finish_byte();
        wr(2'd1, 8'hFE);
        stop_bus("R12 end");

        // R9 arbitration loss
        wr(2'd2, 8'h08);
        start_addr(8'h80);
        jam = 1'b1;
        poll(8'h02, 8'h02, "R9 wait");
        jam = 1'b0;
        rdr(2'd1, s);
        chk("R9 al flag", {31'd0, s[3]}, 32'd1);
        chk("R11 irq al", {31'd0, irq}, 32'd1);
        wr(2'd1, 8'hF5);
        poll(8'h01, 8'h01, "R9 dte");
        wr(2'd1, 8'hF0);
        stop_bus("R9 end");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog all: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule